// File: doc/BRIEF.md
# Four-Slot Address Breakpoint Comparator

This block watches the address stream of a processor core and flags any access that falls inside one of four programmable watch windows. Each window has a base address register. A shared 32-bit control word sets, for each window, two enable bits, the access kind it reacts to and the size of the region it covers. The region is aligned to its own size by masking the low bits of the base address. An access is a hit when its own byte range overlaps the region.

When one or more enabled windows hit, the matching bits of a sticky 4-bit status word are set. In the following cycle the block also raises a one-cycle debug request. Software programs the block through a simple write port. Software also clears the status word, because the hardware only ever sets its bits. A task-switch strobe clears the per-task (local) enables and leaves the global enables as they were.

The access interface is a stream with a valid qualifier and no ready signal. The block takes one access in every cycle where `acc_valid` is high and never applies back-pressure, so a producer never has to wait. The control and status pins are plain levels.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset, `ctrl_q` and `stat_q` are zero and `dbg_req` is low.
- R2: Window i is active when control bit 2i (local enable) or bit 2i+1 (global enable) is set. A window with both bits clear never hits.
- R3: When `task_switch` is high, control bits 0, 2, 4 and 6 become zero at that clock edge and all other bits keep their values. If a control write occurs in the same cycle, the written value is stored with those four bits cleared.
- R4: The kind field of window i sits at control bits [17+4i:16+4i]. Code 00 hits only fetches (`acc_kind`=0). Code 01 hits only writes (`acc_kind`=2). Code 11 hits reads (`acc_kind`=1) or writes.
- R5: A window whose kind code is 10 never hits, whatever the access.
- R6: The length field of window i sits at control bits [19+4i:18+4i]. Codes 00, 01, 11 and 10 watch 1, 2, 4 and 8 bytes. The watched region starts at the base address with its low bits cleared to a multiple of that size.
- R7: An access covers 2^`acc_size` bytes starting at `acc_addr`. It hits when any of those bytes lies inside the watched region.
- R8: A hit in the cycle where `acc_valid` is high sets status bit i at the next clock edge. `dbg_req` is high for exactly that next cycle. All windows that hit in the same cycle set their bits together.
- R9: Status bits are sticky. Only a write with `cfg_wr_sel`=5 changes them, and it loads `cfg_wr_data[3:0]`. A hardware hit in the same cycle is ORed into the written value.
- R10: `cfg_wr_sel` 0 to 3 loads the base address of window 0 to 3, and 4 loads the control word. Values 6 and 7 change no state.
- R11: When `acc_valid` is low, no window hits and no request or status bit results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select: 0-3 base, 4 control, 5 status |
| cfg_wr_data | input | 32 | Write data |
| task_switch | input | 1 | Task-switch strobe, clears local enables |
| acc_valid | input | 1 | Access stream valid (always accepted) |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write |
| acc_addr | input | AW | Access start address |
| acc_size | input | 2 | Access size as log2 of the byte count |
| ctrl_q | output | 32 | Current control word |
| stat_q | output | 4 | Sticky hit status |
| dbg_req | output | 1 | One-cycle debug request |

## Verification
Every result in this block is due one clock edge after its cause. A register write or a task-switch strobe shows on `ctrl_q` and `stat_q` in the next cycle. An access shows on `stat_q` and `dbg_req` in the cycle after it is presented. The bench drives inputs on the falling edge and holds them for one full cycle. It samples at the following falling edge, which is exactly one rising edge later. It samples once more a cycle after that to confirm that the request has dropped while the status bits hold. The same-cycle cases are driven in a single cycle and checked one edge later: a task switch together with a control write, and a status write together with a hit.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  localparam int NSLOT   = 4;
  localparam int CW      = 32;
  localparam int SEL_W   = 3;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;
  localparam logic [CW-1:0]    LOCAL_EN_MASK = 32'h0000_0055;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    WK_EXEC  = 2'b00,
    WK_WRITE = 2'b01,
    WK_IO    = 2'b10,
    WK_RDWR  = 2'b11
  } watch_kind_e;

  // byte count of a length code (non-monotonic encoding)
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   len_bytes = 4'd1;
      2'b01:   len_bytes = 4'd2;
      2'b11:   len_bytes = 4'd4;
      default: len_bytes = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/dbg_bkpt_regs.sv
module dbg_bkpt_regs
  import dbg_bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [CW-1:0]            wr_data,
  input  logic                     task_sw,
  input  logic [NSLOT-1:0]         hit,
  output logic [NSLOT-1:0][AW-1:0] base_q,
  output logic [CW-1:0]            ctrl_q,
  output logic [NSLOT-1:0]         stat_q
);
  logic [CW-1:0]    ctrl_nx;
  logic [NSLOT-1:0] stat_nx;

  always_comb begin
    ctrl_nx = (wr_en && wr_sel == SEL_CTRL) ? wr_data : ctrl_q;
    if (task_sw) ctrl_nx = ctrl_nx & ~LOCAL_EN_MASK;
    stat_nx = (wr_en && wr_sel == SEL_STAT) ? wr_data[NSLOT-1:0] : stat_q;
    stat_nx = stat_nx | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
      stat_q <= stat_nx;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        base_q[s] <= '0;
      else if (wr_en && wr_sel == SEL_W'(s))
        base_q[s] <= AW'(wr_data);
    end
  end
endmodule

// File: rtl/dbg_bkpt_slot.sv
module dbg_bkpt_slot
  import dbg_bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [1:0]    en,
  input  logic [1:0]    kind,
  input  logic [1:0]    len,
  input  logic          acc_valid,
  input  logic [1:0]    acc_kind,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  output logic          hit
);
  localparam int XW = AW + 1;

  logic [XW-1:0] w_lo, w_hi, a_lo, a_hi;
  logic [AW-1:0] w_mask;
  logic [3:0]    a_bytes;
  logic          kind_ok;

  always_comb begin
    w_mask  = AW'(len_bytes(len)) - AW'(1);
    w_lo    = {1'b0, base & ~w_mask};
    w_hi    = w_lo + XW'(w_mask);
    a_bytes = 4'd1 << acc_size;
    a_lo    = {1'b0, acc_addr};
    a_hi    = a_lo + XW'(a_bytes) - XW'(1);
    case (watch_kind_e'(kind))
      WK_EXEC:  kind_ok = (acc_kind == ACC_FETCH);
      WK_WRITE: kind_ok = (acc_kind == ACC_WRITE);
      WK_RDWR:  kind_ok = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
      default:  kind_ok = 1'b0;
    endcase
    hit = acc_valid && (|en) && kind_ok && (a_lo <= w_hi) && (w_lo <= a_hi);
  end
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import dbg_bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [2:0]       cfg_wr_sel,
  input  logic [31:0]      cfg_wr_data,
  input  logic             task_switch,
  input  logic             acc_valid,
  input  logic [1:0]       acc_kind,
  input  logic [AW-1:0]    acc_addr,
  input  logic [1:0]       acc_size,
  output logic [31:0]      ctrl_q,
  output logic [3:0]       stat_q,
  output logic             dbg_req
);
  logic [NSLOT-1:0][AW-1:0] base_q;
  logic [NSLOT-1:0]         hit;

  dbg_bkpt_regs #(.AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_wr_sel),
    .wr_data (cfg_wr_data),
    .task_sw (task_switch),
    .hit     (hit),
    .base_q  (base_q),
    .ctrl_q  (ctrl_q),
    .stat_q  (stat_q)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    dbg_bkpt_slot #(.AW(AW)) u_slot (
      .base      (base_q[s]),
      .en        (ctrl_q[2*s+1 -: 2]),
      .kind      (ctrl_q[16+4*s +: 2]),
      .len       (ctrl_q[18+4*s +: 2]),
      .acc_valid (acc_valid),
      .acc_kind  (acc_kind),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .hit       (hit[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_req <= 1'b0;
    else        dbg_req <= |hit;
  end
endmodule

// File: rtl/dbg_bkpt_chk.sv
module dbg_bkpt_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr_en,
  input logic [2:0]    cfg_wr_sel,
  input logic          task_switch,
  input logic          acc_valid,
  input logic [31:0]   ctrl_q,
  input logic [3:0]    stat_q,
  input logic          dbg_req
);
  // R11
  req_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> $past(acc_valid));

  // R8
  req_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> (stat_q != 4'd0));

  // R9
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr_en && cfg_wr_sel == 3'd5) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R3
  local_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(task_switch) |-> ((ctrl_q & 32'h55) == 32'h0));

  // R2
  no_enable_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_q[7:0]) == 8'h00) |-> !dbg_req);
endmodule

bind dbg_bkpt_unit dbg_bkpt_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_sel  (cfg_wr_sel),
  .task_switch (task_switch),
  .acc_valid   (acc_valid),
  .ctrl_q      (ctrl_q),
  .stat_q      (stat_q),
  .dbg_req     (dbg_req)
);

// File: tb/test_dbg_bkpt_unit.sv
module test_dbg_bkpt_unit;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [2:0]    cfg_wr_sel = '0;
  logic [31:0]   cfg_wr_data = '0;
  logic          task_switch = 1'b0;
  logic          acc_valid = 1'b0;
  logic [1:0]    acc_kind = '0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_size = '0;
  logic [31:0]   ctrl_q;
  logic [3:0]    stat_q;
  logic          dbg_req;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  dbg_bkpt_unit #(.AW(AW)) i_dbg_bkpt_unit (
    .clk, .rst_n, .cfg_wr_en, .cfg_wr_sel, .cfg_wr_data, .task_switch,
    .acc_valid, .acc_kind, .acc_addr, .acc_size, .ctrl_q, .stat_q, .dbg_req
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // present one access, check request and status one edge later, then the drop
  task automatic access(input string tag, input logic [1:0] kind, input logic [31:0] addr,
                        input logic [1:0] size, input logic exp_req, input logic [3:0] exp_stat);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = kind; acc_addr = addr; acc_size = size;
    @(negedge clk);
    acc_valid = 1'b0;
    chk({tag, " req"}, 32'(dbg_req), 32'(exp_req));
    chk({tag, " stat"}, 32'(stat_q), 32'(exp_stat));
    @(negedge clk);
    chk({tag, " R8 req pulse"}, 32'(dbg_req), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl_q, 32'd0);
    chk("R1 stat", 32'(stat_q), 32'd0);
    chk("R1 req", 32'(dbg_req), 32'd0);
  endtask

  task automatic t_exec;
    wr(3'd0, 32'h1000);
    wr(3'd4, 32'h0000_0001);
    access("R4 fetch hit", 2'd0, 32'h1000, 2'd0, 1'b1, 4'b0001);
    access("R4 read ignored by exec", 2'd1, 32'h1000, 2'd0, 1'b0, 4'b0001);
    repeat (3) @(negedge clk);
    chk("R9 status holds", 32'(stat_q), 32'h1);
    wr(3'd5, 32'h0);
    chk("R9 status cleared", 32'(stat_q), 32'h0);
  endtask

  task automatic t_write_len4;
    wr(3'd1, 32'h2004);
    wr(3'd4, 32'h00D0_0008);
    access("R4 write hit", 2'd2, 32'h2006, 2'd0, 1'b1, 4'b0010);
    wr(3'd5, 32'h0);
    access("R4 read ignored by write kind", 2'd1, 32'h2006, 2'd0, 1'b0, 4'b0000);
    access("R6 past 4-byte end", 2'd2, 32'h2008, 2'd0, 1'b0, 4'b0000);
    access("R7 2-byte overlap low", 2'd2, 32'h2003, 2'd1, 1'b1, 4'b0010);
    wr(3'd5, 32'h0);
    access("R7 2-byte just below", 2'd2, 32'h2002, 2'd1, 1'b0, 4'b0000);
  endtask

  task automatic t_len8;
    wr(3'd2, 32'h300C);
    wr(3'd4, 32'h0B00_0010);
    access("R6 8-byte aligned start", 2'd1, 32'h3008, 2'd0, 1'b1, 4'b0100);
    wr(3'd5, 32'h0);
    access("R6 8-byte past end", 2'd2, 32'h3010, 2'd0, 1'b0, 4'b0000);
    access("R7 4-byte overlap", 2'd2, 32'h3006, 2'd2, 1'b1, 4'b0100);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_io_kind;
    wr(3'd3, 32'h4000);
    wr(3'd4, 32'h2000_0040);
    access("R5 io kind fetch", 2'd0, 32'h4000, 2'd0, 1'b0, 4'b0000);
    access("R5 io kind read", 2'd1, 32'h4000, 2'd0, 1'b0, 4'b0000);
    access("R5 io kind write", 2'd2, 32'h4000, 2'd0, 1'b0, 4'b0000);
  endtask

  task automatic t_disabled;
    wr(3'd0, 32'h1000);
    wr(3'd4, 32'h0003_0000);
    access("R2 no enable", 2'd2, 32'h1000, 2'd0, 1'b0, 4'b0000);
    wr(3'd4, 32'h0003_0002);
    access("R2 global enable", 2'd2, 32'h1000, 2'd0, 1'b1, 4'b0001);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_multi;
    wr(3'd0, 32'h5000);
    wr(3'd2, 32'h5000);
    wr(3'd4, 32'h0303_0021);
    access("R8 two slots together", 2'd2, 32'h5000, 2'd0, 1'b1, 4'b0101);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_valid_low;
    @(negedge clk);
    acc_valid = 1'b0; acc_kind = 2'd2; acc_addr = 32'h5000; acc_size = 2'd0;
    @(negedge clk);
    chk("R11 idle req", 32'(dbg_req), 32'd0);
    chk("R11 idle stat", 32'(stat_q), 32'd0);
  endtask

  task automatic t_task_switch;
    wr(3'd4, 32'h0000_00FF);
    @(negedge clk);
    task_switch = 1'b1;
    @(negedge clk);
    task_switch = 1'b0;
    chk("R3 locals cleared", ctrl_q, 32'h0000_00AA);
    @(negedge clk);
    task_switch = 1'b1; cfg_wr_en = 1'b1; cfg_wr_sel = 3'd4; cfg_wr_data = 32'h0003_000F;
    @(negedge clk);
    task_switch = 1'b0; cfg_wr_en = 1'b0;
    chk("R3 write with switch", ctrl_q, 32'h0003_000A);
  endtask

  task automatic t_stat_write;
    // slot 0 at 0x5000, read/write kind, global enable from previous task
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 3'd5; cfg_wr_data = 32'h8;
    acc_valid = 1'b1; acc_kind = 2'd2; acc_addr = 32'h5000; acc_size = 2'd0;
    @(negedge clk);
    cfg_wr_en = 1'b0; acc_valid = 1'b0;
    chk("R9 write ORed with hit", 32'(stat_q), 32'h9);
    wr(3'd5, 32'h3);
    chk("R9 write loads value", 32'(stat_q), 32'h3);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0);
    chk("R10 sel 6/7 ctrl", ctrl_q, 32'h0003_000A);
    chk("R10 sel 6/7 stat", 32'(stat_q), 32'h3);
    access("R10 base unchanged", 2'd1, 32'h5000, 2'd0, 1'b1, 4'b0011);
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_exec;
    t_write_len4;
    t_len8;
    t_io_kind;
    t_disabled;
    t_multi;
    t_valid_low;
    t_task_switch;
    t_stat_write;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule